// File: doc/BRIEF.md
# Long Multiply-Accumulate Unit

This unit produces a 64-bit result from two 32-bit multiplicand sources and a 64-bit accumulator that arrives as two separate 32-bit words. The result leaves as two 32-bit words. A 4-bit opcode selects one of thirteen operations. Four of them can update negative and zero flags: unsigned and signed full-width long multiply, and unsigned and signed long multiply-accumulate. The other nine never touch the flags. They are a double-addend unsigned accumulate, four single 16-bit halfword long accumulates, and four dual 16-bit forms that add or subtract, with or without exchanged halves, into the 64-bit accumulator.

The unit has one register stage. Operands are captured on the rising edge at which `in_valid` is high. The result, the flag write enable and the flags appear on the outputs in the following cycle, and a new operation can be accepted every cycle. An asynchronous active-low reset clears the unit, and the release of that reset is synchronised inside the unit.

Top module: `lmac64_unit`

## Requirements
- R1: While reset is active and until the first accepted operation, `out_valid`, `res_lo`, `res_hi`, `flag_we`, `flag_n` and `flag_z` are all zero.
- R2: An operation sampled with `in_valid` high at a rising edge presents its result in the next cycle, with `out_valid` high for exactly that one cycle. While `in_valid` is low, `out_valid` is low and `res_lo` and `res_hi` keep the last result.
- R3: Opcode 0 returns the full unsigned 64-bit product of `src_a` and `src_b`. Opcode 1 returns the product of both sources taken as signed 32-bit values. Bits 31:0 go to `res_lo` and bits 63:32 go to `res_hi`.
- R4: Opcode 2 adds the unsigned product, and opcode 3 adds the signed product, to the accumulator `{acc_hi, acc_lo}`.
- R5: Opcode 4 adds the unsigned product, zero-extended `acc_lo` and zero-extended `acc_hi`, each as a separate 32-bit addend.
- R6: Opcodes 5 to 8 multiply one signed 16-bit half of `src_a` by one signed 16-bit half of `src_b` and add the product to the accumulator. The halves are a-low×b-low (5), a-low×b-high (6), a-high×b-low (7) and a-high×b-high (8).
- R7: Opcode 9 adds (low×low + high×high) to the accumulator, and opcode 10 adds (a-low×b-high + a-high×b-low). Opcode 11 adds (low×low − high×high), and opcode 12 adds (a-low×b-high − a-high×b-low). All halves are signed 16-bit values.
- R8: For opcodes 0 to 3 with `set_flags` high, `flag_we` is high with the result. `flag_n` then equals result bit 63, and `flag_z` is high exactly when all 64 result bits are zero.
- R9: For opcodes 4 to 12, or when `set_flags` is low, `flag_we`, `flag_n` and `flag_z` are zero.
- R10: Opcodes 13 to 15 are reserved. They give a zero result with `out_valid` high and no flag write.
- R11: All arithmetic wraps modulo 2^64. No overflow is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and opcode valid this cycle |
| op | input | 4 | Operation code (see R3 to R10) |
| set_flags | input | 1 | Request a flag update (opcodes 0 to 3 only) |
| src_a | input | 32 | First multiplicand source |
| src_b | input | 32 | Second multiplicand source |
| acc_lo | input | 32 | Accumulator bits 31:0 |
| acc_hi | input | 32 | Accumulator bits 63:32 |
| out_valid | output | 1 | Result valid |
| res_lo | output | 32 | Result bits 31:0 |
| res_hi | output | 32 | Result bits 63:32 |
| flag_we | output | 1 | Flags are written this cycle |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench builds the unit with its default word width of 32. At this width the 64-bit bench arithmetic is an exact model, and the extreme operands can be reached directly. These include all-ones sources, where the double-addend form lands exactly on 2^64−1. They also include -32768 halves, whose dual sum reaches +2^31 and must not spill a sign into the high word. With the width fixed, the stimulus concentrates on half selection, exchange pairing, signed-against-unsigned treatment of identical bit patterns, and flag gating across back-to-back operations.

// File: rtl/lmac64_pkg.sv
package lmac64_pkg;

  typedef enum logic [3:0] {
    OP_UMUL  = 4'd0,
    OP_SMUL  = 4'd1,
    OP_UMAC  = 4'd2,
    OP_SMAC  = 4'd3,
    OP_UDAC  = 4'd4,
    OP_HBB   = 4'd5,
    OP_HBT   = 4'd6,
    OP_HTB   = 4'd7,
    OP_HTT   = 4'd8,
    OP_DSUM  = 4'd9,
    OP_DSUMX = 4'd10,
    OP_DDIF  = 4'd11,
    OP_DDIFX = 4'd12
  } lmac_op_e;

  // Only the full-width multiply and multiply-accumulate codes may write flags.
  function automatic logic op_can_flag(input logic [3:0] code);
    return (code <= 4'(OP_SMAC));
  endfunction

  // Codes whose halfword lanes use crossed pairing of the b halves.
  function automatic logic op_crossed(input logic [3:0] code);
    return (code == 4'(OP_HBT)) || (code == 4'(OP_HTB)) ||
           (code == 4'(OP_DSUMX)) || (code == 4'(OP_DDIFX));
  endfunction

endpackage

// File: rtl/lmac64_wide_mul.sv
module lmac64_wide_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sgn,
  output logic [2*W-1:0] prod
);
  localparam int RW = 2 * W;

  logic [RW-1:0] a_ext;
  logic [RW-1:0] b_ext;

  // Extending to the full result width and keeping the low RW bits gives
  // the exact two's-complement product for either signedness.
  assign a_ext = {{W{sgn & a[W-1]}}, a};
  assign b_ext = {{W{sgn & b[W-1]}}, b};
  assign prod  = a_ext * b_ext;

endmodule

// File: rtl/lmac64_half_pair.sv
module lmac64_half_pair #(
  parameter int W = 32
) (
  input  logic [W-1:0]        a,
  input  logic [W-1:0]        b,
  input  logic                crossed,
  output logic [1:0][W-1:0]   lane_prod
);
  localparam int HW = W / 2;

  // Lane i always takes half i of a; b supplies half i, or the other half
  // when crossed pairing is requested.
  for (genvar i = 0; i < 2; i++) begin : g_lane
    logic [HW-1:0] a_half;
    logic [HW-1:0] b_half;
    logic [W-1:0]  a_wide;
    logic [W-1:0]  b_wide;

    assign a_half = a[i*HW +: HW];
    assign b_half = crossed ? b[(1-i)*HW +: HW] : b[i*HW +: HW];
    assign a_wide = {{HW{a_half[HW-1]}}, a_half};
    assign b_wide = {{HW{b_half[HW-1]}}, b_half};
    assign lane_prod[i] = a_wide * b_wide;
  end

endmodule

// File: rtl/lmac64_unit.sv
module lmac64_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic         set_flags,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [W-1:0] acc_lo,
  input  logic [W-1:0] acc_hi,
  output logic         out_valid,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi,
  output logic         flag_we,
  output logic         flag_n,
  output logic         flag_z
);
  import lmac64_pkg::*;

  localparam int RW = 2 * W;

  // ---------------- reset release synchroniser ----------------
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // ---------------- datapath ----------------
  logic                sgn_long;
  logic                crossed;
  logic [RW-1:0]       wide_prod;
  logic [1:0][W-1:0]   lane_prod;
  logic [RW-1:0]       acc64;
  logic [RW-1:0]       lane0_ext;
  logic [RW-1:0]       lane1_ext;
  logic [RW-1:0]       nxt_res;
  logic                nxt_we;
  logic                nxt_n;
  logic                nxt_z;

  assign sgn_long = (op == OP_SMUL) || (op == OP_SMAC);
  assign crossed  = op_crossed(op);

  lmac64_wide_mul #(.W(W)) u_wide (
    .a    (src_a),
    .b    (src_b),
    .sgn  (sgn_long),
    .prod (wide_prod)
  );

  lmac64_half_pair #(.W(W)) u_pair (
    .a         (src_a),
    .b         (src_b),
    .crossed   (crossed),
    .lane_prod (lane_prod)
  );

  assign acc64     = {acc_hi, acc_lo};
  assign lane0_ext = {{W{lane_prod[0][W-1]}}, lane_prod[0]};
  assign lane1_ext = {{W{lane_prod[1][W-1]}}, lane_prod[1]};

  always_comb begin
    case (op)
      OP_UMUL, OP_SMUL:   nxt_res = wide_prod;
      OP_UMAC, OP_SMAC:   nxt_res = wide_prod + acc64;
      OP_UDAC:            nxt_res = wide_prod + {{W{1'b0}}, acc_lo}
                                              + {{W{1'b0}}, acc_hi};
      OP_HBB, OP_HBT:     nxt_res = lane0_ext + acc64;
      OP_HTB, OP_HTT:     nxt_res = lane1_ext + acc64;
      OP_DSUM, OP_DSUMX:  nxt_res = lane0_ext + lane1_ext + acc64;
      OP_DDIF, OP_DDIFX:  nxt_res = lane0_ext - lane1_ext + acc64;
      default:            nxt_res = '0;
    endcase
  end

  always_comb begin
    nxt_we = in_valid & set_flags & op_can_flag(op);
    nxt_n  = nxt_we & nxt_res[RW-1];
    nxt_z  = nxt_we & (nxt_res == '0);
  end

  // ---------------- output registers ----------------
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      flag_we   <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      flag_we   <= nxt_we;
      flag_n    <= nxt_n;
      flag_z    <= nxt_z;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_lo <= '0;
      res_hi <= '0;
    end else if (in_valid) begin
      res_lo <= nxt_res[W-1:0];
      res_hi <= nxt_res[RW-1:W];
    end
  end

  // ---------------- assertions ----------------
  assert_valid_next_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);

  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid);

  assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> ($stable(res_lo) && $stable(res_hi)));

  assert_neg_flag_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    flag_we |-> (flag_n == res_hi[W-1]));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_we && flag_z) |-> (res_lo == '0 && res_hi == '0));

  assert_flag_gate_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    flag_we |-> out_valid);

  assert_flag_quiet_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !flag_we |-> (!flag_n && !flag_z));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op > 4'd12) |=> (res_lo == '0 && res_hi == '0 && !flag_we));

endmodule

// File: tb/lmac64_unit_tb.sv
`timescale 1ns/1ps
module lmac64_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic        set_flags;
  logic [31:0] src_a, src_b, acc_lo, acc_hi;
  logic        out_valid;
  logic [31:0] res_lo, res_hi;
  logic        flag_we, flag_n, flag_z;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [63:0] r;
    logic        we;
    logic        n;
    logic        z;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] last_res = '0;
  logic        monitor_on = 1'b0;

  always #2.5 clk = ~clk;

  lmac64_unit #(.W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .set_flags(set_flags), .src_a(src_a), .src_b(src_b),
    .acc_lo(acc_lo), .acc_hi(acc_hi), .out_valid(out_valid),
    .res_lo(res_lo), .res_hi(res_hi), .flag_we(flag_we),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  function automatic longint sh(input logic [15:0] h);
    return longint'(shortint'(h));
  endfunction

  // Expected value built from the requirements with 64-bit host arithmetic.
  function automatic exp_t model(input logic [3:0] code, input logic [31:0] a, b,
                                 input logic [31:0] lo, hi, input logic sf,
                                 input string tag);
    exp_t        e;
    longint      acc;
    longint      ua, ub, sa, sb_;
    longint      al, ah, bl, bh;
    acc = longint'({hi, lo});
    ua  = longint'({32'd0, a});
    ub  = longint'({32'd0, b});
    sa  = longint'(int'(a));
    sb_ = longint'(int'(b));
    al  = sh(a[15:0]);  ah = sh(a[31:16]);
    bl  = sh(b[15:0]);  bh = sh(b[31:16]);
    case (code)
      4'd0:  e.r = 64'(ua * ub);
      4'd1:  e.r = 64'(sa * sb_);
      4'd2:  e.r = 64'(ua * ub + acc);
      4'd3:  e.r = 64'(sa * sb_ + acc);
      4'd4:  e.r = 64'(ua * ub + longint'({32'd0, lo}) + longint'({32'd0, hi}));
      4'd5:  e.r = 64'(al * bl + acc);
      4'd6:  e.r = 64'(al * bh + acc);
      4'd7:  e.r = 64'(ah * bl + acc);
      4'd8:  e.r = 64'(ah * bh + acc);
      4'd9:  e.r = 64'(al * bl + ah * bh + acc);
      4'd10: e.r = 64'(al * bh + ah * bl + acc);
      4'd11: e.r = 64'(al * bl - ah * bh + acc);
      4'd12: e.r = 64'(al * bh - ah * bl + acc);
      default: e.r = 64'd0;
    endcase
    e.we  = sf && (code <= 4'd3);
    e.n   = e.we && e.r[63];
    e.z   = e.we && (e.r == 64'd0);
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [3:0] code, input logic [31:0] a, b, lo, hi,
                      input logic sf, input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    op        = code;
    src_a     = a;
    src_b     = b;
    acc_lo    = lo;
    acc_hi    = hi;
    set_flags = sf;
    sb.push_back(model(code, a, b, lo, hi, sf, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      op        = 4'd0;
      set_flags = 1'b0;
    end
  endtask

  // Monitor: pop the oldest expectation whenever a result appears.
  always @(negedge clk) begin
    if (monitor_on && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected out_valid: actual res=%h expected no result",
                 {res_hi, res_lo});
      end else begin
        exp_t e;
        e = sb.pop_front();
        last_res = e.r;
        if ({res_hi, res_lo} !== e.r || flag_we !== e.we ||
            flag_n !== e.n || flag_z !== e.z) begin
          errors++;
          $display("FAIL %s: actual res=%h we=%b n=%b z=%b expected res=%h we=%b n=%b z=%b",
                   e.tag, {res_hi, res_lo}, flag_we, flag_n, flag_z,
                   e.r, e.we, e.n, e.z);
        end
      end
    end
  end

  task automatic check_idle(input string tag);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || {res_hi, res_lo} !== last_res ||
        flag_we !== 1'b0 || flag_n !== 1'b0 || flag_z !== 1'b0) begin
      errors++;
      $display("FAIL %s: actual v=%b res=%h we=%b n=%b z=%b expected v=0 res=%h flags 0",
               tag, out_valid, {res_hi, res_lo}, flag_we, flag_n, flag_z, last_res);
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual run still going expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = 4'd0; set_flags = 1'b0;
    src_a = '0; src_b = '0; acc_lo = '0; acc_hi = '0;
    repeat (3) @(negedge clk);
    check_idle("R1 during reset");
    rst_n = 1'b1;
    idle(4);
    check_idle("R1 after reset release");
    monitor_on = 1'b1;

    // R3 long multiply, same bit patterns as unsigned and signed
    send(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0, "R3 umul all ones");
    send(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0, "R3 smul minus one squared");
    send(4'd1, 32'h8000_0000, 32'h0000_0002, 32'h0, 32'h0, 1'b0, "R3 smul most negative");
    send(4'd0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0, 32'h0, 1'b0, "R3 umul mixed");
    // R4 / R11 accumulate, including wrap
    send(4'd3, 32'hFFFF_FFF0, 32'h0000_0100, 32'h0000_0001, 32'h0000_0000, 1'b0, "R4 smac negative product");
    send(4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R11 umac wrap");
    send(4'd3, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'hC000_0000, 1'b0, "R11 smac wrap to zero");
    // R5 double addend
    send(4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5 udac maximum");
    send(4'd4, 32'd2, 32'd3, 32'd5, 32'd7, 1'b0, "R5 udac separate addends");
    idle(2);
    check_idle("R2 hold while idle");

    // R6 halfword selection
    send(4'd5, 32'h8000_0003, 32'hFFFE_7FFF, 32'd10, 32'd0, 1'b0, "R6 low x low");
    send(4'd6, 32'h8000_0003, 32'hFFFE_7FFF, 32'd10, 32'd0, 1'b0, "R6 low x high");
    send(4'd7, 32'h8000_0003, 32'hFFFE_7FFF, 32'd10, 32'd0, 1'b0, "R6 high x low");
    send(4'd8, 32'h8000_0003, 32'hFFFE_7FFF, 32'd10, 32'd0, 1'b0, "R6 high x high");
    // R7 dual forms
    send(4'd9,  32'h0005_0003, 32'hFFF9_0002, 32'd100, 32'd0, 1'b0, "R7 dual sum");
    send(4'd10, 32'h0005_0003, 32'hFFF9_0002, 32'd100, 32'd0, 1'b0, "R7 dual sum crossed");
    send(4'd11, 32'h0005_0003, 32'hFFF9_0002, 32'd100, 32'd0, 1'b0, "R7 dual difference");
    send(4'd12, 32'h0005_0003, 32'hFFF9_0002, 32'd100, 32'd0, 1'b0, "R7 dual difference crossed");
    send(4'd9,  32'h8000_8000, 32'h8000_8000, 32'd0, 32'd0, 1'b0, "R7 dual sum reaches 2^31");
    send(4'd11, 32'h7FFF_8000, 32'h8000_8000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R7 dual difference into negative acc");

    // R8 flags
    send(4'd1, 32'h0, 32'h1234_5678, 32'h0, 32'h0, 1'b1, "R8 zero flag");
    send(4'd1, 32'hFFFF_FFFF, 32'h0000_0005, 32'h0, 32'h0, 1'b1, "R8 negative flag");
    send(4'd2, 32'h1, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R8 umac wrap to zero flag");
    send(4'd0, 32'h0001_0000, 32'h0001_0000, 32'h0, 32'h0, 1'b1, "R8 positive nonzero");
    // R9 no flag update
    send(4'd5, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, "R9 halfword ignores set_flags");
    send(4'd9, 32'hFFFF_FFFF, 32'h0001_0001, 32'h0, 32'h0, 1'b1, "R9 dual ignores set_flags");
    send(4'd1, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, "R9 set_flags low");
    // R10 reserved
    send(4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, 32'h1, 1'b1, "R10 reserved 13");
    send(4'd14, 32'h1234_0000, 32'h5678_0000, 32'h1, 32'h1, 1'b1, "R10 reserved 14");
    send(4'd15, 32'h1, 32'h1, 32'h1, 32'h1, 1'b0, "R10 reserved 15");
    idle(3);
    check_idle("R2 no spurious result");

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2 results missing: actual %0d pending expected 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule